// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block turns one selected stream of source edges into three banks of divided clocks and one feedback clock. The source can be an internal fast clock or either of two reference clocks. All of them reach the block as single-cycle strobes in one system clock domain, so choosing between them never cuts a clock pulse short. A shared pre-divider feeds the three bank dividers. The feedback divider counts source edges directly, because its divide-by-6 setting needs a toggle every three edges.

Each bank has its own ratio select. Every output has a 50 percent duty cycle and begins each period high. A change to a select input waits for the next period boundary of its divider. An active-low stop input parks the bank outputs low, but only after the current high phase has finished. An active-low master reset clears every counter and holds all outputs low. When the reset is released, all outputs rise together on the first selected source edge.

Top module: `clkdiv_banks`

## Requirements
- R1: The selected source is `vco_tick` when `pll_en`=1. When `pll_en`=0, it is `ref0_tick` if `ref_sel`=0 and `ref1_tick` if `ref_sel`=1. Strobes on the lines that are not selected have no effect on any output.
- R2: The bank pre-divide factor P is 2 when `pre_sel`=0 and 4 when `pre_sel`=1. The feedback output does not depend on `pre_sel`.
- R3: Bank A divides the selected source by 2·P when `sel_a`=0 and by 4·P when `sel_a`=1. Bank B does the same with `sel_b`. All bits of `qa` carry the same value, and all bits of `qb` carry the same value.
- R4: Bank C divides by 4·P when `sel_c`=0 and by 6·P when `sel_c`=1. All bits of `qc` carry the same value.
- R5: `fb_out` divides by 4, 6, 8 or 12 for `fb_sel` = 00, 01, 10 or 11. It is not affected by `stop_n`.
- R6: An output with ratio N is high for the first N/2 source edges of each period and low for the remaining N/2. Counting the first edge after reset as edge 0, the output is high after edge k exactly when (k mod N) < N/2.
- R7: While `mr_n`=0, every output is low and every counter is cleared. After release, all outputs rise on the first selected source edge.
- R8: A change to `sel_a`, `sel_b`, `sel_c` or `fb_sel` is taken at the next rising boundary of that divider. The period in progress completes with the old ratio. `pre_sel` is taken when the pre-divider wraps.
- R9: While `stop_n`=0, a bank output finishes its current high phase and then stays low. The divider keeps counting. After `stop_n` returns to 1, the output resumes with a full high phase at the divider's next rising boundary.
- R10: Outputs change only at the clock edge that samples a selected source strobe. Without such a strobe they hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| mr_n | input | 1 | Active-low master reset / output enable, asynchronous assert |
| vco_tick | input | 1 | Strobe: one edge of the internal fast clock |
| ref0_tick | input | 1 | Strobe: one edge of reference clock 0 |
| ref1_tick | input | 1 | Strobe: one edge of reference clock 1 |
| pll_en | input | 1 | 1 selects the fast clock; 0 bypasses to a reference |
| ref_sel | input | 1 | Reference choice in bypass: 0 = ref0, 1 = ref1 |
| pre_sel | input | 1 | Bank pre-divide: 0 = by 2, 1 = by 4 |
| sel_a | input | 1 | Bank A ratio select |
| sel_b | input | 1 | Bank B ratio select |
| sel_c | input | 1 | Bank C ratio select |
| fb_sel | input | 2 | Feedback ratio select |
| stop_n | input | 1 | Active-low stop for the bank outputs |
| qa | output | NA (5) | Bank A clocks |
| qb | output | NB (5) | Bank B clocks |
| qc | output | NC (4) | Bank C clocks |
| fb_out | output | 1 | Feedback clock |

## Verification
The assertions take each source strobe to be a level sampled once per `clk` edge. They assume that `stop_n` and the selects change synchronously, and that `mr_n` is released away from an active edge. The stimulus respects all of this. Every input is driven on the falling edge of `clk`, and each strobe is held for exactly one cycle. Pulses on the unselected lines are always sent in cycles of their own, apart from the selected strobes, so each observed output change can be traced to a single selected edge.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
    // Widest half-period count (feedback /12 toggles every 6 edges)
    localparam int HALF_MAX = 6;
    localparam int HALF_W   = $clog2(HALF_MAX + 1);
    localparam int PRE_W    = 2;

    typedef logic [HALF_W-1:0] half_t;

    // Bank A/B half-period, counted in pre-divider strobes
    function automatic half_t half_ab(input logic sel);
        return sel ? half_t'(2) : half_t'(1);
    endfunction

    // Bank C half-period, counted in pre-divider strobes
    function automatic half_t half_c(input logic sel);
        return sel ? half_t'(3) : half_t'(2);
    endfunction

    // Feedback half-period, counted in source edges
    function automatic half_t half_fb(input logic [1:0] sel);
        case (sel)
            2'b00:   return half_t'(2);
            2'b01:   return half_t'(3);
            2'b10:   return half_t'(4);
            default: return half_t'(6);
        endcase
    endfunction
endpackage

// File: rtl/clkdiv_src_sel.sv
`timescale 1ns/1ps
module clkdiv_src_sel (
    input  logic pll_en,
    input  logic ref_sel,
    input  logic vco_tick,
    input  logic ref0_tick,
    input  logic ref1_tick,
    output logic src_tick
);
    logic ref_tick;

    always_comb begin
        ref_tick = ref_sel ? ref1_tick : ref0_tick;
        src_tick = pll_en ? vco_tick : ref_tick;
    end
endmodule

// File: rtl/clkdiv_prediv.sv
`timescale 1ns/1ps
module clkdiv_prediv
    import clkdiv_pkg::*;
(
    input  logic clk,
    input  logic mr_n,
    input  logic src_tick,
    input  logic pre_sel,
    output logic pre_tick
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        pre_tick = 1'b0;
        if (src_tick) begin
            if (st_q.cnt == '0) begin
                pre_tick   = 1'b1;
                // factor is sampled only at the wrap point
                st_d.cnt   = pre_sel ? PRE_W'(3) : PRE_W'(1);
            end else begin
                st_d.cnt   = st_q.cnt - PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge mr_n) begin
        if (!mr_n) st_q <= '0;
        else       st_q <= st_d;
    end
endmodule

// File: rtl/clkdiv_half_div.sv
`timescale 1ns/1ps
module clkdiv_half_div #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          mr_n,
    input  logic          adv,
    input  logic [CW-1:0] half_nxt,
    input  logic          run,
    output logic          clk_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] half;
        logic          phase;
        logic          gate;
        logic          out;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            if (st_q.cnt == '0) begin
                if (!st_q.phase) begin
                    // rising boundary: take new ratio and stop state
                    st_d.half  = half_nxt;
                    st_d.cnt   = half_nxt - ONE;
                    st_d.phase = 1'b1;
                    st_d.gate  = run;
                end else begin
                    st_d.cnt   = st_q.half - ONE;
                    st_d.phase = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
        st_d.out = st_d.phase & st_d.gate;
    end

    always_ff @(posedge clk or negedge mr_n) begin
        if (!mr_n) st_q <= '0;
        else       st_q <= st_d;
    end

    assign clk_o = st_q.out;
endmodule

// File: rtl/clkdiv_banks.sv
`timescale 1ns/1ps
module clkdiv_banks
    import clkdiv_pkg::*;
#(
    parameter int NA = 5,
    parameter int NB = 5,
    parameter int NC = 4
) (
    input  logic          clk,
    input  logic          mr_n,
    input  logic          vco_tick,
    input  logic          ref0_tick,
    input  logic          ref1_tick,
    input  logic          pll_en,
    input  logic          ref_sel,
    input  logic          pre_sel,
    input  logic          sel_a,
    input  logic          sel_b,
    input  logic          sel_c,
    input  logic [1:0]    fb_sel,
    input  logic          stop_n,
    output logic [NA-1:0] qa,
    output logic [NB-1:0] qb,
    output logic [NC-1:0] qc,
    output logic          fb_out
);
    localparam int NBANK = 3;

    logic  src_tick;
    logic  pre_tick;
    half_t bank_half [NBANK];
    logic  [NBANK-1:0] bank_clk;

    clkdiv_src_sel u_src (
        .pll_en    (pll_en),
        .ref_sel   (ref_sel),
        .vco_tick  (vco_tick),
        .ref0_tick (ref0_tick),
        .ref1_tick (ref1_tick),
        .src_tick  (src_tick)
    );

    clkdiv_prediv u_pre (
        .clk      (clk),
        .mr_n     (mr_n),
        .src_tick (src_tick),
        .pre_sel  (pre_sel),
        .pre_tick (pre_tick)
    );

    always_comb begin
        bank_half[0] = half_ab(sel_a);
        bank_half[1] = half_ab(sel_b);
        bank_half[2] = half_c(sel_c);
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        clkdiv_half_div #(.CW(HALF_W)) u_div (
            .clk      (clk),
            .mr_n     (mr_n),
            .adv      (pre_tick),
            .half_nxt (bank_half[g]),
            .run      (stop_n),
            .clk_o    (bank_clk[g])
        );
    end

    clkdiv_half_div #(.CW(HALF_W)) u_fb (
        .clk      (clk),
        .mr_n     (mr_n),
        .adv      (src_tick),
        .half_nxt (half_fb(fb_sel)),
        .run      (1'b1),
        .clk_o    (fb_out)
    );

    assign qa = {NA{bank_clk[0]}};
    assign qb = {NB{bank_clk[1]}};
    assign qc = {NC{bank_clk[2]}};
endmodule

// File: rtl/clkdiv_banks_chk.sv
`timescale 1ns/1ps
module clkdiv_banks_chk #(
    parameter int NA = 5,
    parameter int NB = 5,
    parameter int NC = 4
) (
    input logic          clk,
    input logic          mr_n,
    input logic          vco_tick,
    input logic          ref0_tick,
    input logic          ref1_tick,
    input logic          pll_en,
    input logic          ref_sel,
    input logic          stop_n,
    input logic [NA-1:0] qa,
    input logic [NB-1:0] qb,
    input logic [NC-1:0] qc,
    input logic          fb_out
);
    logic chosen;
    assign chosen = pll_en ? vco_tick : (ref_sel ? ref1_tick : ref0_tick);

    // R7: quiet while master reset is held
    always @(posedge clk) begin
        if (!mr_n) begin
            p_quiet_in_reset_r7: assert (qa == '0 && qb == '0 && qc == '0 && !fb_out)
                else $error("outputs active during master reset");
        end
    end

    // R10 / R1: no selected strobe, no output change
    p_hold_without_tick_r10: assert property (@(posedge clk) disable iff (!mr_n)
        !chosen |=> ($stable(qa) && $stable(qb) && $stable(qc) && $stable(fb_out)));

    // R9: a stopped bank that is low stays low
    p_stop_keeps_a_low_r9: assert property (@(posedge clk) disable iff (!mr_n)
        (!stop_n && qa == '0) |=> qa == '0);
    p_stop_keeps_b_low_r9: assert property (@(posedge clk) disable iff (!mr_n)
        (!stop_n && qb == '0) |=> qb == '0);
    p_stop_keeps_c_low_r9: assert property (@(posedge clk) disable iff (!mr_n)
        (!stop_n && qc == '0) |=> qc == '0);
endmodule

bind clkdiv_banks clkdiv_banks_chk #(.NA(NA), .NB(NB), .NC(NC)) u_chk (
    .clk       (clk),
    .mr_n      (mr_n),
    .vco_tick  (vco_tick),
    .ref0_tick (ref0_tick),
    .ref1_tick (ref1_tick),
    .pll_en    (pll_en),
    .ref_sel   (ref_sel),
    .stop_n    (stop_n),
    .qa        (qa),
    .qb        (qb),
    .qc        (qc),
    .fb_out    (fb_out)
);

// File: tb/clkdiv_banks_test.sv
`timescale 1ns/1ps
module clkdiv_banks_test;
    localparam int NA = 5;
    localparam int NB = 5;
    localparam int NC = 4;

    // {pll_en, ref_sel, pre_sel, sel_a, sel_b, sel_c, fb_sel[1:0]}
    localparam logic [7:0] VEC [8] = '{
        8'b1_0_0_0_1_0_00,
        8'b1_0_0_1_0_1_01,
        8'b0_0_0_0_0_1_10,
        8'b0_1_0_1_1_0_11,
        8'b1_1_1_0_1_1_01,
        8'b0_1_1_1_0_0_00,
        8'b1_0_1_1_1_1_11,
        8'b0_0_1_0_0_0_10
    };

    logic clk = 1'b0;
    logic mr_n = 1'b0;
    logic pll_en = 1'b1, ref_sel = 1'b0, pre_sel = 1'b0;
    logic sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0, stop_n = 1'b1;
    logic [1:0] fb_sel = 2'b00;
    logic [2:0] tk = 3'b000;   // [0] vco, [1] ref0, [2] ref1
    logic [NA-1:0] qa;
    logic [NB-1:0] qb;
    logic [NC-1:0] qc;
    logic fb_out;
    int nchk = 0, nfail = 0;

    always #2.5 clk = ~clk;

    clkdiv_banks #(.NA(NA), .NB(NB), .NC(NC)) uut (
        .clk(clk), .mr_n(mr_n), .vco_tick(tk[0]), .ref0_tick(tk[1]),
        .ref1_tick(tk[2]), .pll_en(pll_en), .ref_sel(ref_sel),
        .pre_sel(pre_sel), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
        .fb_sel(fb_sel), .stop_n(stop_n), .qa(qa), .qb(qb), .qc(qc),
        .fb_out(fb_out)
    );

    function automatic logic lv(int k, int n);
        return (k % n) < (n / 2);
    endfunction

    function automatic logic [7:0] rep(int w, logic b);
        return b ? ((8'd1 << w) - 8'd1) : 8'd0;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic pulse(logic [2:0] m);
        @(negedge clk); tk = m;
        @(negedge clk); tk = 3'b000;
    endtask

    task automatic do_reset();
        @(negedge clk); mr_n = 1'b0; tk = 3'b000;
        pulse(3'b111);
        chk("R7 reset quiet A", 8'(qa), 8'd0);
        chk("R7 reset quiet B", 8'(qb), 8'd0);
        chk("R7 reset quiet C", 8'(qc), 8'd0);
        chk("R7 reset quiet FB", 8'(fb_out), 8'd0);
        @(negedge clk); mr_n = 1'b1;
    endtask

    function automatic logic [2:0] sel_mask();
        return pll_en ? 3'b001 : (ref_sel ? 3'b100 : 3'b010);
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // ---------------- vector table: R1 R2 R3 R4 R5 R6 ----------------
        for (int v = 0; v < 8; v++) begin
            int p, na, nb, nc, nf;
            logic [2:0] m;
            {pll_en, ref_sel, pre_sel, sel_a, sel_b, sel_c, fb_sel} = VEC[v];
            stop_n = 1'b1;
            do_reset();
            p  = pre_sel ? 4 : 2;
            na = p * (sel_a ? 4 : 2);
            nb = p * (sel_b ? 4 : 2);
            nc = p * (sel_c ? 6 : 4);
            nf = (fb_sel == 2'b00) ? 4 : (fb_sel == 2'b01) ? 6 :
                 (fb_sel == 2'b10) ? 8 : 12;
            m  = sel_mask();
            for (int k = 0; k < 48; k++) begin
                pulse(m);
                chk($sformatf("R1 R2 R3 R6 v%0d k%0d bank A", v, k), 8'(qa), rep(NA, lv(k, na)));
                chk($sformatf("R1 R2 R3 R6 v%0d k%0d bank B", v, k), 8'(qb), rep(NB, lv(k, nb)));
                chk($sformatf("R1 R2 R4 R6 v%0d k%0d bank C", v, k), 8'(qc), rep(NC, lv(k, nc)));
                chk($sformatf("R1 R5 R6 v%0d k%0d feedback", v, k), 8'(fb_out), 8'(lv(k, nf)));
                pulse(~m);   // unselected lines: no effect
            end
        end

        // ---------------- R8: select change at boundary ----------------
        {pll_en, ref_sel, pre_sel, sel_a, sel_b, sel_c, fb_sel} = 8'b1_0_0_0_0_0_00;
        do_reset();
        for (int k = 0; k <= 12; k++) begin
            pulse(3'b001);
            if (k == 1) begin sel_a = 1'b1; fb_sel = 2'b01; end
            if (k == 2)  chk("R8 A old ratio falls k2", 8'(qa), rep(NA, 1'b0));
            if (k == 4)  chk("R8 A rises k4", 8'(qa), rep(NA, 1'b1));
            if (k == 7)  chk("R8 A new ratio high k7", 8'(qa), rep(NA, 1'b1));
            if (k == 8)  chk("R8 A new ratio low k8", 8'(qa), rep(NA, 1'b0));
            if (k == 12) chk("R8 A rises k12", 8'(qa), rep(NA, 1'b1));
            if (k == 5)  chk("R8 B unchanged k5", 8'(qb), rep(NB, 1'b1));
            if (k == 2)  chk("R8 FB old ratio k2", 8'(fb_out), 8'd0);
            if (k == 6)  chk("R8 FB new ratio high k6", 8'(fb_out), 8'd1);
            if (k == 7)  chk("R8 FB new ratio low k7", 8'(fb_out), 8'd0);
            if (k == 10) chk("R8 FB rises k10", 8'(fb_out), 8'd1);
        end

        // ---------------- R9: clock stop ----------------
        {pll_en, ref_sel, pre_sel, sel_a, sel_b, sel_c, fb_sel} = 8'b1_0_0_1_0_0_00;
        stop_n = 1'b1;
        do_reset();
        for (int k = 0; k <= 20; k++) begin
            pulse(3'b001);
            if (k == 1) stop_n = 1'b0;
            if (k == 9) stop_n = 1'b1;
            if (k == 2)  chk("R9 A finishes high k2", 8'(qa), rep(NA, 1'b1));
            if (k == 3)  chk("R9 A finishes high k3", 8'(qa), rep(NA, 1'b1));
            if (k == 4)  chk("R9 A parked low k4", 8'(qa), rep(NA, 1'b0));
            if (k == 8)  chk("R9 A stays low k8", 8'(qa), rep(NA, 1'b0));
            if (k == 12) chk("R9 A waits boundary k12", 8'(qa), rep(NA, 1'b0));
            if (k == 16) chk("R9 A resumes k16", 8'(qa), rep(NA, 1'b1));
            if (k == 19) chk("R9 A full high k19", 8'(qa), rep(NA, 1'b1));
            if (k == 20) chk("R9 A falls k20", 8'(qa), rep(NA, 1'b0));
            if (k == 4)  chk("R9 B blocked k4", 8'(qb), rep(NB, 1'b0));
            if (k == 8)  chk("R9 B blocked k8", 8'(qb), rep(NB, 1'b0));
            if (k == 10) chk("R9 B waits k10", 8'(qb), rep(NB, 1'b0));
            if (k == 12) chk("R9 B resumes k12", 8'(qb), rep(NB, 1'b1));
            if (k == 4)  chk("R5 FB runs in stop k4", 8'(fb_out), 8'd1);
            if (k == 6)  chk("R5 FB runs in stop k6", 8'(fb_out), 8'd0);
            if (k == 8)  chk("R5 FB runs in stop k8", 8'(fb_out), 8'd1);
        end

        // ---------------- R7 / R10: reset mid-run, in-phase restart ----------------
        {pll_en, ref_sel, pre_sel, sel_a, sel_b, sel_c, fb_sel} = 8'b0_1_1_1_0_1_11;
        do_reset();
        for (int k = 0; k < 5; k++) pulse(3'b100);
        chk("R7 running before reset", 8'(qa), rep(NA, 1'b1));
        @(negedge clk); mr_n = 1'b0; #1;
        chk("R7 mid-run reset A", 8'(qa), 8'd0);
        chk("R7 mid-run reset FB", 8'(fb_out), 8'd0);
        @(negedge clk); mr_n = 1'b1;
        @(negedge clk); tk = 3'b100; #1;
        chk("R10 no change before edge", 8'(qa), 8'd0);
        @(negedge clk); tk = 3'b000;
        chk("R7 in-phase A", 8'(qa), rep(NA, 1'b1));
        chk("R7 in-phase B", 8'(qb), rep(NB, 1'b1));
        chk("R7 in-phase C", 8'(qc), rep(NC, 1'b1));
        chk("R7 in-phase FB", 8'(fb_out), 8'd1);

        finish_run();
    end
endmodule